// File: doc/BRIEF.md
# MDIO Management Master with Register Port

This block lets software reach Ethernet PHY management registers over the two-wire serial management bus defined in IEEE 802.3. Software loads a clause-select bit, a PHY/device address word and a 16-bit data word through a small 32-bit register port. It then writes a command word that carries a start strobe and a two-bit access code. The block builds the 64-bit serial frame and drives it on MDIO. MDC is derived from the system clock. A busy flag stays set until the last bit time has finished. For a read frame, the 16 bits returned by the PHY are kept in a read-data register.

One command register serves both clauses, and the clause bit decides how the access code is understood. Under Clause 22 a transfer is a single frame. Under Clause 45 software issues the steps one at a time: first an address frame that carries the register number from the data register, then a write or a read frame that acts on that address inside the PHY. While a frame is running, software may reload the setup registers; the running frame keeps the values it captured at its start.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag (command word bit 16) reads 0, the read-data register reads 0, MDC is low and the MDIO output enable is low.
- R2: MDC has a period of CLK_DIV clock cycles (default 40, which gives 2.5 MHz from 100 MHz), with equal high and low halves.
- R3: A Clause 22 write (mode bit 8 = 0, access code 1) sends 32 ones, start 01, opcode 01, the PHY address (address word bits 12:8), the register number (bits 4:0), turnaround 10 and the 16 data bits, all most significant bit first, with the output enable high for all 64 bits.
- R4: A read frame (Clause 22 code 0, opcode 10; Clause 45 code 2) releases MDIO for the two turnaround bits and the 16 data bits. It samples MDIO on the rising MDC edge, MSB first, and places the result in the read-data register (offset 0x4C) only as the frame ends.
- R5: A Clause 45 address frame (mode bit 8 = 1, code 0) sends start 00, opcode 00, the PHY address, the device number from address word bits 4:0, turnaround 10 and the data register value as the register address.
- R6: A Clause 45 write (code 1) uses opcode 01 and a Clause 45 read (code 2) uses opcode 11. Both use start 00.
- R7: Busy rises only in the cycle after a command write (offset 0x50) with bit 8 set. It stays set until the 64th bit time ends. While busy is clear, the output enable is low.
- R8: A start strobe written while busy is set is ignored: the running frame goes on unchanged and no further frame follows.
- R9: Writes to the address (0x44) and data (0x48) registers while busy are stored and read back, but do not alter the running frame.
- R10: A start with an undefined access code (codes 2 and 3 in Clause 22, code 3 in Clause 45) is ignored and busy stays clear.
- R11: Write and address frames leave the read-data register unchanged.
- R12: MDIO data and output enable change only together with a falling MDC edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The checker watches the MDC half-period length, the rule that pad values move only on a falling MDC edge, the link between busy and a command write, the output enable being low when idle, forward progress of the bit index inside a frame, and read-data updates happening only as busy falls. Only the bench scenarios can show the exact 64-bit content of each frame type and the captured read value returned by a modelled PHY. The same holds for rejection of undefined codes and of a start issued mid-frame, and for setup writes that are stored without disturbing the frame in flight.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_MODE = 8'h40;
  localparam logic [REG_AW-1:0] OFS_ADDR = 8'h44;
  localparam logic [REG_AW-1:0] OFS_WDAT = 8'h48;
  localparam logic [REG_AW-1:0] OFS_RDAT = 8'h4C;
  localparam logic [REG_AW-1:0] OFS_CMD  = 8'h50;

  localparam int unsigned CLAUSE_BIT = 8;
  localparam int unsigned START_BIT  = 8;
  localparam int unsigned BUSY_BIT   = 16;

  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned TA_POS     = 46;
  localparam int unsigned DATA_POS   = 48;

  typedef struct packed {
    logic        c45;
    logic [1:0]  code;
    logic [4:0]  phy;
    logic [4:0]  dev;
    logic [15:0] wd;
  } mdio_req_t;

  function automatic logic code_ok(input logic c45, input logic [1:0] code);
    return c45 ? (code != 2'd3) : (code[1] == 1'b0);
  endfunction

  function automatic logic code_reads(input logic c45, input logic [1:0] code);
    return c45 ? (code == 2'd2) : (code == 2'd0);
  endfunction

  function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_req_t r);
    logic [1:0] st;
    logic [1:0] op;
    logic       rd;
    rd = code_reads(r.c45, r.code);
    st = r.c45 ? 2'b00 : 2'b01;
    if (r.c45) op = (r.code == 2'd0) ? 2'b00 : (r.code == 2'd1) ? 2'b01 : 2'b11;
    else       op = (r.code == 2'd0) ? 2'b10 : 2'b01;
    return {32'hFFFF_FFFF, st, op, r.phy, r.dev, 2'b10, (rd ? 16'h0000 : r.wd)};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;

  assign rise_tick = (cnt_q == CW'(HALF - 1));
  assign fall_tick = (cnt_q == CW'(CLK_DIV - 1));
  assign mdc       = mdc_q;

  always_comb begin
    cnt_d = fall_tick ? '0 : cnt_q + 1'b1;
    mdc_d = mdc_q;
    if (rise_tick) mdc_d = 1'b1;
    if (fall_tick) mdc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  input  logic              busy,
  input  logic              rd_done,
  input  logic [15:0]       rd_cap,
  output logic              start,
  output mdio_req_t         req,
  output logic [15:0]       rd_word
);
  logic        c45_q, c45_d;
  logic [4:0]  phy_q, phy_d;
  logic [4:0]  dev_q, dev_d;
  logic [15:0] wd_q, wd_d;
  logic [1:0]  code_q, code_d;
  logic [15:0] rd_q, rd_d;
  logic        wr_en;
  logic        unused_hi;

  assign wr_en     = bus_sel && bus_we;
  assign unused_hi = &{1'b0, bus_wdata[REG_DW-1:16]};

  assign start = wr_en && (bus_addr == OFS_CMD) && bus_wdata[START_BIT] &&
                 !busy && code_ok(c45_q, bus_wdata[1:0]);
  assign req   = '{c45: c45_q, code: bus_wdata[1:0], phy: phy_q, dev: dev_q, wd: wd_q};
  assign rd_word = rd_q;

  always_comb begin
    c45_d  = c45_q;
    phy_d  = phy_q;
    dev_d  = dev_q;
    wd_d   = wd_q;
    code_d = code_q;
    rd_d   = rd_q;
    if (wr_en) begin
      case (bus_addr)
        OFS_MODE: c45_d = bus_wdata[CLAUSE_BIT];
        OFS_ADDR: begin
          phy_d = bus_wdata[12:8];
          dev_d = bus_wdata[4:0];
        end
        OFS_WDAT: wd_d = bus_wdata[15:0];
        default: ;
      endcase
    end
    if (start) code_d = bus_wdata[1:0];
    if (rd_done) rd_d = rd_cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q  <= 1'b0;
      phy_q  <= '0;
      dev_q  <= '0;
      wd_q   <= '0;
      code_q <= '0;
      rd_q   <= '0;
    end else begin
      c45_q  <= c45_d;
      phy_q  <= phy_d;
      dev_q  <= dev_d;
      wd_q   <= wd_d;
      code_q <= code_d;
      rd_q   <= rd_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE: bus_rdata[CLAUSE_BIT] = c45_q;
      OFS_ADDR: begin
        bus_rdata[12:8] = phy_q;
        bus_rdata[4:0]  = dev_q;
      end
      OFS_WDAT: bus_rdata[15:0] = wd_q;
      OFS_RDAT: bus_rdata[15:0] = rd_q;
      OFS_CMD: begin
        bus_rdata[BUSY_BIT] = busy;
        bus_rdata[1:0]      = code_q;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             start,
  input  mdio_req_t        req,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             busy,
  output logic [IDX_W-1:0] bit_idx,
  output logic             rd_done,
  output logic [15:0]      rd_cap
);
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic                  busy_q, busy_d;
  logic                  act_q, act_d;
  logic                  isrd_q, isrd_d;
  logic                  o_q, o_d;
  logic                  oe_q, oe_d;
  logic [15:0]           cap_q, cap_d;

  assign mdio_o  = o_q;
  assign mdio_oe = oe_q;
  assign busy    = busy_q;
  assign bit_idx = idx_q;
  assign rd_cap  = cap_q;

  always_comb begin
    sh_d    = sh_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    act_d   = act_q;
    isrd_d  = isrd_q;
    o_d     = o_q;
    oe_d    = oe_q;
    cap_d   = cap_q;
    rd_done = 1'b0;
    if (start) begin
      busy_d = 1'b1;
      act_d  = 1'b0;
      idx_d  = '0;
      sh_d   = frame_bits(req);
      isrd_d = code_reads(req.c45, req.code);
    end else if (busy_q && fall_tick) begin
      if (!act_q) begin
        act_d = 1'b1;
        idx_d = '0;
        o_d   = sh_q[FRAME_BITS-1];
        oe_d  = 1'b1;
        sh_d  = sh_q << 1;
      end else if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
        busy_d  = 1'b0;
        act_d   = 1'b0;
        oe_d    = 1'b0;
        o_d     = 1'b1;
        rd_done = isrd_q;
      end else begin
        idx_d = idx_q + 1'b1;
        o_d   = sh_q[FRAME_BITS-1];
        sh_d  = sh_q << 1;
        oe_d  = !(isrd_q && (idx_d >= IDX_W'(TA_POS)));
      end
    end else if (busy_q && act_q && rise_tick && isrd_q &&
                 (idx_q >= IDX_W'(DATA_POS))) begin
      cap_d = {cap_q[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      isrd_q <= 1'b0;
      o_q    <= 1'b1;
      oe_q   <= 1'b0;
      cap_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      act_q  <= act_d;
      isrd_q <= isrd_d;
      o_q    <= o_d;
      oe_q   <= oe_d;
      cap_q  <= cap_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             rise_tick, fall_tick;
  logic             start, busy, rd_done;
  logic [IDX_W-1:0] bit_idx;
  logic [15:0]      rd_cap, rd_word;
  mdio_req_t        req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_ni), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_ni),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rd_done(rd_done), .rd_cap(rd_cap),
    .start(start), .req(req), .rd_word(rd_word)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_ni),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(start), .req(req), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .busy(busy),
    .bit_idx(bit_idx), .rd_done(rd_done), .rd_cap(rd_cap)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
  import mdio_pkg::*;
#(
  parameter int unsigned CLK_DIV = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic [IDX_W-1:0]  bit_idx,
  input logic [15:0]       rd_word,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic [REG_DW-1:0] bus_wdata
);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic        mdc_d;
  logic [15:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d <= 1'b0;
      gap   <= '0;
    end else begin
      mdc_d <= mdc;
      gap   <= (mdc != mdc_d) ? 16'd1 : gap + 16'd1;
    end
  end

  AST_MDC_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_d) |-> (gap == 16'(HALF))); // R2

  AST_PIN_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdio_o != $past(mdio_o)) || (mdio_oe != $past(mdio_oe))) |-> $fell(mdc)); // R12

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_we && (bus_addr == OFS_CMD) && bus_wdata[START_BIT])); // R7

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R7

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bit_idx >= $past(bit_idx))); // R8

  AST_RDATA_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_word != $past(rd_word)) |-> $fell(busy)); // R4
endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_ni), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .bit_idx(bit_idx), .rd_word(rd_word),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 40;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDAT = 8'h48,
                         A_RDAT = 8'h4C, A_CMD = 8'h50;

  logic        clk, rst_n, bus_sel, bus_we, mdc, mdio_i, mdio_o, mdio_oe;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  mdio_master #(.CLK_DIV(DIV)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit exp_v[$];
  bit exp_oe[$];
  bit frame_on, phy_rd, mdc_d, done;
  int popped, mism, extra, cyc, last_rise, period;
  logic [15:0] phy_word;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference: expected pin value per rising MDC edge
  always @(negedge clk) begin
    bit v, o;
    cyc++;
    if (mdc && !mdc_d) begin
      period = cyc - last_rise;
      last_rise = cyc;
      if (exp_v.size() > 0 && (frame_on || mdio_oe)) begin
        frame_on = 1;
        v = exp_v.pop_front();
        o = exp_oe.pop_front();
        if (mdio_oe !== o || (o && mdio_o !== v)) begin
          mism++;
          $display("  bit %0d mismatch oe=%b o=%b want oe=%b o=%b", popped, mdio_oe, mdio_o, o, v);
        end
        popped++;
      end else if (exp_v.size() == 0 && mdio_oe) extra++;
    end
    if (!mdc && mdc_d) begin
      if (phy_rd && popped >= 48 && popped < 64) mdio_i = phy_word[63-popped];
      else mdio_i = 1'b1;
    end
    mdc_d = mdc;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push(input int val, input int n, input bit oe);
    for (int i = n - 1; i >= 0; i--) begin
      exp_v.push_back(val[i]);
      exp_oe.push_back(oe);
    end
  endtask

  task automatic expect_frame(input bit c45, input int code, input int phy, input int dev,
                              input int data, input bit isrd, input logic [15:0] ret);
    exp_v.delete(); exp_oe.delete();
    frame_on = 0; popped = 0; mism = 0;
    phy_rd = isrd; phy_word = ret;
    push(32'hFFFF_FFFF, 32, 1);
    push(c45 ? 0 : 1, 2, 1);
    if (c45) push(code == 0 ? 0 : code == 1 ? 1 : 3, 2, 1);
    else     push(code == 0 ? 2 : 1, 2, 1);
    push(phy, 5, 1);
    push(dev, 5, 1);
    if (isrd) begin push(0, 2, 0); push(0, 16, 0); end
    else      begin push(2, 2, 1); push(data, 16, 1); end
  endtask

  task automatic run(input bit c45, input int code, input int phy, input int dev,
                     input int data, input bit isrd, input logic [15:0] ret);
    wr(A_MODE, c45 ? 32'h100 : 32'h0);
    wr(A_ADDR, (phy << 8) | dev);
    wr(A_WDAT, data);
    expect_frame(c45, code, phy, dev, data, isrd, ret);
    wr(A_CMD, 32'h100 | code);
  endtask

  task automatic finish_frame(input string req);
    logic [31:0] d;
    int n;
    n = 0;
    d = 32'h1_0000;
    while (d[16] && n < 6000) begin rd(A_CMD, d); n++; end
    check(!d[16], {req, " busy clears"}, d[16], 0);
    check(popped == 64, {req, " bit count"}, popped, 64);
    check(mism == 0, {req, " frame bits"}, mism, 0);
  endtask

  initial begin
    logic [31:0] d;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; mdio_i = 1;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(mdc == 0 && mdio_oe == 0, "R1 pins", {mdc, mdio_oe}, 0);
    rd(A_CMD, d);  check(d[16] == 0, "R1 busy", d, 0);
    rd(A_RDAT, d); check(d == 0, "R1 rdata", d, 0);

    run(0, 1, 5, 5'h1A, 16'hBEEF, 0, 0);
    repeat (100) @(negedge clk);
    rd(A_CMD, d); check(d[16] == 1, "R7 busy mid frame", d[16], 1);
    finish_frame("R3 c22 write");
    check(period == DIV, "R2 mdc period", period, DIV);

    run(0, 0, 5'h11, 2, 0, 1, 16'hA5C3);
    finish_frame("R4 c22 read");
    rd(A_RDAT, d); check(d == 32'hA5C3, "R4 rdata", d, 32'hA5C3);

    run(1, 0, 3, 1, 16'h1234, 0, 0);
    finish_frame("R5 c45 address");
    run(1, 1, 3, 1, 16'h5678, 0, 0);
    finish_frame("R6 c45 write");
    rd(A_RDAT, d); check(d == 32'hA5C3, "R11 rdata kept", d, 32'hA5C3);
    run(1, 2, 3, 1, 0, 1, 16'h0F0F);
    finish_frame("R6 c45 read");
    rd(A_RDAT, d); check(d == 32'h0F0F, "R4 c45 rdata", d, 32'h0F0F);

    run(0, 1, 7, 3, 16'h1357, 0, 0);
    repeat (600) @(negedge clk);
    wr(A_ADDR, 32'h1F1F);
    wr(A_WDAT, 32'hFFFF);
    wr(A_CMD, 32'h101);
    finish_frame("R8 R9 frame kept");
    rd(A_ADDR, d); check(d == 32'h1F1F, "R9 addr stored", d, 32'h1F1F);
    rd(A_WDAT, d); check(d == 32'hFFFF, "R9 wdata stored", d, 32'hFFFF);
    extra = 0;
    repeat (3000) @(negedge clk);
    check(extra == 0, "R8 no second frame", extra, 0);

    wr(A_MODE, 32'h0); wr(A_CMD, 32'h102);
    rd(A_CMD, d); check(d[16] == 0, "R10 c22 code 2", d[16], 0);
    wr(A_MODE, 32'h100); wr(A_CMD, 32'h103);
    rd(A_CMD, d); check(d[16] == 0, "R10 c45 code 3", d[16], 0);
    repeat (200) @(negedge clk);
    check(extra == 0 && mdio_oe == 0, "R10 no frame", extra, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog R7 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule